// File: doc/BRIEF.md
# Dual 16-bit Timer with Match Interrupts

This peripheral holds two independent 16-bit counters and a shared bank of six match registers. Each counter has a prescale divider and a control word. The control word starts or halts the counter, sets whether it counts up or down, and selects when it stops on its own. It can stop on reaching zero, stop on reaching one chosen match value, or never stop and wrap around.

A match comparator fires when a count step lands a counter on the value held in a match register. Each firing latches a status bit for that match register. Software reads these status bits, masks them, and clears them by writing ones. The single interrupt line is high while any unmasked status bit is set.

Software reaches every register through a synchronous write strobe and a combinational read port that share one byte address. A common use is to run one counter as a free-running time base while the other serves as a one-shot event timer. For the one-shot role, software loads a delay, lets the counter count down to a match, and takes the interrupt.

Top module: `dual_match_timer`

## Requirements
- R1: After reset both control words read 0x10 (halted, down, mode 0), every counter, divider, match, status and mask register reads 0, and `irq` is low.
- R2: Counter k (k = 0, 1) has its value at byte address 12·k, its divider at 12·k+4 and its control at 12·k+8. Match register x (x = 0..5) is at 0x18+4·x. The status/acknowledge register is at 0x40 and the mask is at 0x44. Written values read back, and any other address reads 0.
- R3: A divider value N makes a running counter take one step every N+1 clock cycles. The first step comes N+1 cycles after the edge that wrote the control word that started it.
- R4: Control bit 3 picks the step: 1 adds one and 0 subtracts one, modulo 2^16.
- R5: Control bits 2:0 = 0: when a step lands the counter on 0, the counter keeps that value and control bit 4 becomes 1.
- R6: Control bits 2:0 = m with 1 ≤ m ≤ 6: when a step lands the counter on match register m−1, it keeps that value and control bit 4 becomes 1.
- R7: Control bits 2:0 = 7: the counter never halts by itself and wraps from 0xFFFF to 0 (up) or from 0 to 0xFFFF (down).
- R8: Status bit n (bits 5:0) is set when a step of either counter lands on match register n, whatever the mask. It stays set until software clears it.
- R9: `irq` is high exactly when (status AND mask) is nonzero.
- R10: Writing to 0x40 clears each status bit whose data bit is 1 and leaves the others. When a clear and a set of the same bit happen in one cycle, the clear wins.
- R11: A write to a counter's value register in the same cycle as that counter's step stores the written value, and no step or match is applied that cycle.
- R12: While control bit 4 is 1, the counter value does not change except by a software write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Byte address for read and write |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Combinational read data for `addr` |
| irq | output | 1 | Interrupt, OR of unmasked status bits |

## Verification
The bench runs the counters through wrap points and terminal values. A design that checked the old value instead of the stepped value, or that let the wrap skip 0xFFFF, would halt one step late or miss the match. It also places an acknowledge write on the exact cycle a match fires. Giving the set priority over the clear there would leave a stale pending bit. A value write lands on a running counter's step cycle, and a design that lets the step win would read one count too high. A divider of 3 is timed over ten periods, so an off-by-one prescaler drifts by several counts.

// File: rtl/dmt_pkg.sv
package dmt_pkg;

    // Control word: bit 4 halt, bit 3 count direction, bits 2:0 stop mode
    typedef struct packed {
        logic       halt;
        logic       up;
        logic [2:0] mode;
    } tmr_ctrl_t;

    localparam int CTRL_W = $bits(tmr_ctrl_t);

    localparam logic [2:0] MODE_TO_ZERO = 3'd0;
    localparam logic [2:0] MODE_FOREVER = 3'd7;

    // Address layout
    localparam int TMR_STRIDE   = 12;
    localparam int OFS_VAL      = 0;
    localparam int OFS_DIV      = 4;
    localparam int OFS_CTL      = 8;
    localparam int MATCH_STRIDE = 4;
    localparam int IRQ_OFS_STS  = 0;
    localparam int IRQ_OFS_MSK  = 4;

    localparam tmr_ctrl_t CTRL_RESET = '{halt: 1'b1, up: 1'b0, mode: MODE_TO_ZERO};

    // True when the mode names a match register that exists
    function automatic logic mode_uses_match(input logic [2:0] m, input int n_match);
        return (m != MODE_TO_ZERO) && (m != MODE_FOREVER) && (int'(m) <= n_match);
    endfunction

endpackage

// File: rtl/dmt_match_bank.sv
module dmt_match_bank #(
    parameter int CNT_W   = 16,
    parameter int N_MATCH = 6
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [N_MATCH-1:0]              we,
    input  logic [CNT_W-1:0]                wdata,
    output logic [N_MATCH-1:0][CNT_W-1:0]   match_q
);

    for (genvar k = 0; k < N_MATCH; k++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                match_q[k] <= '0;
            end else if (we[k]) begin
                match_q[k] <= wdata;
            end
        end
    end

endmodule

// File: rtl/dmt_timer_unit.sv
module dmt_timer_unit
    import dmt_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int N_MATCH = 6
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            val_we,
    input  logic                            div_we,
    input  logic                            ctl_we,
    input  logic [CNT_W-1:0]                wdata,
    input  logic [N_MATCH-1:0][CNT_W-1:0]   match_vals,
    output logic [CNT_W-1:0]                value,
    output logic [CNT_W-1:0]                divider,
    output tmr_ctrl_t                       ctrl,
    output logic [N_MATCH-1:0]              hit
);

    localparam int SEL_N = 8;

    logic [CNT_W-1:0] presc;
    logic             running;
    logic             tick;
    logic             advance;
    logic [CNT_W-1:0] stepped;
    logic [N_MATCH-1:0] eq;
    logic [SEL_N-1:0] eq_pad;
    logic [2:0]       sel;
    logic             terminal;

    assign running = !ctrl.halt;
    assign tick    = running && (presc == divider);
    assign advance = tick && !val_we;
    assign stepped = ctrl.up ? value + CNT_W'(1) : value - CNT_W'(1);

    for (genvar k = 0; k < N_MATCH; k++) begin : g_cmp
        assign eq[k] = (match_vals[k] == stepped);
    end

    always_comb begin
        eq_pad = '0;
        eq_pad[N_MATCH-1:0] = eq;
    end

    assign sel = ctrl.mode - 3'd1;

    always_comb begin
        if (ctrl.mode == MODE_TO_ZERO) begin
            terminal = (stepped == '0);
        end else if (mode_uses_match(ctrl.mode, N_MATCH)) begin
            terminal = eq_pad[sel];
        end else begin
            terminal = 1'b0;
        end
    end

    assign hit = advance ? eq : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            presc <= '0;
        end else if (!running || val_we || tick) begin
            presc <= '0;
        end else begin
            presc <= presc + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            value <= '0;
        end else if (val_we) begin
            value <= wdata;
        end else if (advance) begin
            value <= stepped;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            divider <= '0;
        end else if (div_we) begin
            divider <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= CTRL_RESET;
        end else if (ctl_we) begin
            ctrl <= tmr_ctrl_t'(wdata[CTRL_W-1:0]);
        end else if (advance && terminal) begin
            ctrl.halt <= 1'b1;
        end
    end

endmodule

// File: rtl/dmt_irq_block.sv
module dmt_irq_block #(
    parameter int N_TIMER = 2,
    parameter int N_MATCH = 6
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [N_TIMER-1:0][N_MATCH-1:0]  hits,
    input  logic                             ack_we,
    input  logic                             mask_we,
    input  logic [N_MATCH-1:0]               wdata,
    output logic [N_MATCH-1:0]               status,
    output logic [N_MATCH-1:0]               mask,
    output logic                             irq
);

    logic [N_MATCH-1:0] any_hit;
    logic [N_MATCH-1:0] clr;

    always_comb begin
        any_hit = '0;
        for (int t = 0; t < N_TIMER; t++) begin
            any_hit = any_hit | hits[t];
        end
    end

    assign clr = ack_we ? wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
        end else begin
            status <= (status | any_hit) & ~clr;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask <= '0;
        end else if (mask_we) begin
            mask <= wdata;
        end
    end

    assign irq = |(status & mask);

endmodule

// File: rtl/dual_match_timer.sv
module dual_match_timer
    import dmt_pkg::*;
#(
    parameter int                 CNT_W    = 16,
    parameter int                 N_TIMER  = 2,
    parameter int                 N_MATCH  = 6,
    parameter int                 ADDR_W   = 8,
    parameter logic [ADDR_W-1:0]  IRQ_BASE = 'h40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [CNT_W-1:0]  rd_data,
    output logic              irq
);

    localparam int MATCH_BASE = N_TIMER * TMR_STRIDE;
    localparam logic [ADDR_W-1:0] STS_ADDR = IRQ_BASE + ADDR_W'(IRQ_OFS_STS);
    localparam logic [ADDR_W-1:0] MSK_ADDR = IRQ_BASE + ADDR_W'(IRQ_OFS_MSK);

    logic [N_TIMER-1:0]                val_we;
    logic [N_TIMER-1:0]                div_we;
    logic [N_TIMER-1:0]                ctl_we;
    logic [N_MATCH-1:0]                match_we;
    logic [N_MATCH-1:0][CNT_W-1:0]     match_q;
    logic [CNT_W-1:0]                  cnt_val [N_TIMER];
    logic [CNT_W-1:0]                  div_val [N_TIMER];
    tmr_ctrl_t                         ctrl_q  [N_TIMER];
    logic [N_TIMER-1:0][N_MATCH-1:0]   hit_vec;
    logic [N_MATCH-1:0]                irq_status;
    logic [N_MATCH-1:0]                irq_mask;

    for (genvar t = 0; t < N_TIMER; t++) begin : g_tmr
        localparam logic [ADDR_W-1:0] BASE = ADDR_W'(t * TMR_STRIDE);

        assign val_we[t] = wr_en && (addr == BASE + ADDR_W'(OFS_VAL));
        assign div_we[t] = wr_en && (addr == BASE + ADDR_W'(OFS_DIV));
        assign ctl_we[t] = wr_en && (addr == BASE + ADDR_W'(OFS_CTL));

        dmt_timer_unit #(
            .CNT_W   (CNT_W),
            .N_MATCH (N_MATCH)
        ) u_unit (
            .clk        (clk),
            .rst        (rst),
            .val_we     (val_we[t]),
            .div_we     (div_we[t]),
            .ctl_we     (ctl_we[t]),
            .wdata      (wr_data),
            .match_vals (match_q),
            .value      (cnt_val[t]),
            .divider    (div_val[t]),
            .ctrl       (ctrl_q[t]),
            .hit        (hit_vec[t])
        );
    end

    for (genvar k = 0; k < N_MATCH; k++) begin : g_mdec
        assign match_we[k] = wr_en && (addr == ADDR_W'(MATCH_BASE + k * MATCH_STRIDE));
    end

    dmt_match_bank #(
        .CNT_W   (CNT_W),
        .N_MATCH (N_MATCH)
    ) u_match (
        .clk     (clk),
        .rst     (rst),
        .we      (match_we),
        .wdata   (wr_data),
        .match_q (match_q)
    );

    dmt_irq_block #(
        .N_TIMER (N_TIMER),
        .N_MATCH (N_MATCH)
    ) u_irq (
        .clk     (clk),
        .rst     (rst),
        .hits    (hit_vec),
        .ack_we  (wr_en && (addr == STS_ADDR)),
        .mask_we (wr_en && (addr == MSK_ADDR)),
        .wdata   (wr_data[N_MATCH-1:0]),
        .status  (irq_status),
        .mask    (irq_mask),
        .irq     (irq)
    );

    always_comb begin
        rd_data = '0;
        for (int t = 0; t < N_TIMER; t++) begin
            if (addr == ADDR_W'(t * TMR_STRIDE + OFS_VAL)) rd_data = cnt_val[t];
            if (addr == ADDR_W'(t * TMR_STRIDE + OFS_DIV)) rd_data = div_val[t];
            if (addr == ADDR_W'(t * TMR_STRIDE + OFS_CTL)) rd_data = CNT_W'(ctrl_q[t]);
        end
        for (int k = 0; k < N_MATCH; k++) begin
            if (addr == ADDR_W'(MATCH_BASE + k * MATCH_STRIDE)) rd_data = match_q[k];
        end
        if (addr == STS_ADDR) rd_data = CNT_W'(irq_status);
        if (addr == MSK_ADDR) rd_data = CNT_W'(irq_mask);
    end

endmodule

// File: rtl/dmt_checker.sv
module dmt_checker #(
    parameter int                 CNT_W    = 16,
    parameter int                 N_MATCH  = 6,
    parameter int                 ADDR_W   = 8,
    parameter logic [ADDR_W-1:0]  IRQ_BASE = 'h40
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [CNT_W-1:0]  wr_data,
    input logic              irq,
    input logic [N_MATCH-1:0] status,
    input logic [N_MATCH-1:0] mask,
    input logic [CNT_W-1:0]  val0,
    input logic [4:0]        ctrl0
);

    // R10: acknowledged bits are clear on the following cycle
    a_r10_ack_clears: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == IRQ_BASE) |=> ((status & $past(wr_data[N_MATCH-1:0])) == '0));

    // R8: without an acknowledge write, no pending bit drops
    a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && addr == IRQ_BASE) |=> ((status & $past(status)) == $past(status)));

    // R9: a fully masked block stays quiet
    a_r9_masked_quiet: assert property (@(posedge clk) disable iff (rst)
        (mask == '0) |-> !irq);

    // R9: the line needs a pending bit behind it
    a_r9_needs_status: assert property (@(posedge clk) disable iff (rst)
        irq |-> (status != '0));

    // R12: a halted counter keeps its value unless written
    a_r12_halt_holds: assert property (@(posedge clk) disable iff (rst)
        (ctrl0[4] && !(wr_en && addr == '0)) |=> $stable(val0));

    // R11: a value write lands exactly, step or not
    a_r11_write_wins: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == '0) |=> (val0 == $past(wr_data)));

    // R5: in mode 0 the counter only halts by itself at zero
    a_r5_zero_stop: assert property (@(posedge clk) disable iff (rst)
        (!ctrl0[4] && ctrl0[2:0] == 3'd0 && !wr_en) |=> (!ctrl0[4] || val0 == '0));

endmodule

bind dual_match_timer dmt_checker #(
    .CNT_W    (CNT_W),
    .N_MATCH  (N_MATCH),
    .ADDR_W   (ADDR_W),
    .IRQ_BASE (IRQ_BASE)
) u_dmt_checker (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .addr    (addr),
    .wr_data (wr_data),
    .irq     (irq),
    .status  (irq_status),
    .mask    (irq_mask),
    .val0    (cnt_val[0]),
    .ctrl0   (ctrl_q[0])
);

// File: tb/test_dual_match_timer.sv
module test_dual_match_timer;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [15:0] wr_data = 16'h0000;
    logic [15:0] rd_data;
    logic        irq;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // reference model state
    int m_val [2];
    int m_div [2];
    int m_ctl [2];
    int m_pre [2];
    int m_match [6];
    int m_sts;
    int m_msk;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_match_timer i_dual_match_timer (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .addr    (addr),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .irq     (irq)
    );

    function automatic int exp_read(input int a);
        int r;
        r = 0;
        for (int t = 0; t < 2; t++) begin
            if (a == t*12)     r = m_val[t];
            if (a == t*12 + 4) r = m_div[t];
            if (a == t*12 + 8) r = m_ctl[t];
        end
        for (int k = 0; k < 6; k++) begin
            if (a == 24 + 4*k) r = m_match[k];
        end
        if (a == 64) r = m_sts;
        if (a == 68) r = m_msk;
        return r;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
        end
    endtask

    // behavioural reference, updated on every clock edge
    always @(posedge clk) begin
        if (rst) begin
            for (int t = 0; t < 2; t++) begin
                m_val[t] = 0; m_div[t] = 0; m_ctl[t] = 16; m_pre[t] = 0;
            end
            for (int k = 0; k < 6; k++) m_match[k] = 0;
            m_sts = 0;
            m_msk = 0;
        end else begin
            int hits;
            int a;
            int wd;
            hits = 0;
            a = int'(addr);
            wd = int'(wr_data);
            for (int t = 0; t < 2; t++) begin
                bit vw, dw, cw, run, tick, adv, term;
                int st, mode;
                vw = wr_en && (a == t*12);
                dw = wr_en && (a == t*12 + 4);
                cw = wr_en && (a == t*12 + 8);
                run = ((m_ctl[t] >> 4) & 1) == 0;
                tick = run && (m_pre[t] == m_div[t]);
                adv = tick && !vw;
                st = (((m_ctl[t] >> 3) & 1) == 1) ? (m_val[t] + 1) & 16'hFFFF
                                                  : (m_val[t] + 65535) & 16'hFFFF;
                mode = m_ctl[t] & 7;
                for (int k = 0; k < 6; k++) begin
                    if (adv && st == m_match[k]) hits = hits | (1 << k);
                end
                if (mode == 0)      term = (st == 0);
                else if (mode == 7) term = 0;
                else                term = (st == m_match[mode-1]);
                if (!run || vw || tick) m_pre[t] = 0;
                else                    m_pre[t] = m_pre[t] + 1;
                if (vw)       m_val[t] = wd;
                else if (adv) m_val[t] = st;
                if (cw)               m_ctl[t] = wd & 31;
                else if (adv && term) m_ctl[t] = m_ctl[t] | 16;
                if (dw) m_div[t] = wd;
            end
            for (int k = 0; k < 6; k++) begin
                if (wr_en && a == 24 + 4*k) m_match[k] = wd;
            end
            m_sts = m_sts | hits;
            if (wr_en && a == 64) m_sts = m_sts & ~(wd & 63);
            if (wr_en && a == 68) m_msk = wd & 63;
        end
    end

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R2 model read", int'(rd_data), exp_read(int'(addr)));
            chk("R9 model irq", int'(irq), ((m_sts & m_msk) != 0) ? 1 : 0);
        end
    end

    // inputs are driven 1 time unit after an edge; this returns at the same point
    task automatic wr(input int a, input int d);
        addr = 8'(a);
        wr_data = 16'(d);
        wr_en = 1'b1;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input string req, input int a, input int exp);
        addr = 8'(a);
        #2;
        chk(req, int'(rd_data), exp);
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;

        // R1 reset state
        rd("R1 ctrl0", 8, 16'h10);
        rd("R1 ctrl1", 20, 16'h10);
        rd("R1 value0", 0, 0);
        rd("R1 status", 64, 0);
        chk("R1 irq", int'(irq), 0);

        // R2 register map
        wr(24, 100); wr(28, 200); wr(32, 300);
        wr(36, 16'h7000); wr(40, 16'hFFFF); wr(44, 50);
        wr(16, 3);
        rd("R2 match5", 44, 50);
        rd("R2 match4", 40, 16'hFFFF);
        rd("R2 div1", 16, 3);
        rd("R2 unmapped", 48, 0);
        wr(68, 16'h2A);
        rd("R2 mask", 68, 16'h2A);
        wr(68, 0);

        // R3 divider of 3: ten steps in forty cycles
        wr(20, 16'h0F);
        cycles(40);
        rd("R3 divided count", 12, 10);
        wr(20, 16'h10);
        // R12 halted counter holds
        cycles(10);
        rd("R12 halted value", 12, 10);

        // R5 count down to zero and halt
        wr(0, 5);
        wr(8, 16'h00);
        cycles(20);
        rd("R5 value at zero", 0, 0);
        rd("R5 halt bit set", 8, 16'h10);
        rd("R5 no match status", 64, 0);

        // R6 count up to match 5 (mode 6), R8 status regardless of mask
        wr(0, 40);
        wr(8, 16'h0E);
        cycles(30);
        rd("R6 value at match5", 0, 50);
        rd("R6 halted in mode 6", 8, 16'h1E);
        rd("R8 status bit5", 64, 16'h20);
        chk("R9 masked irq low", int'(irq), 0);

        // R9 mask opens the line
        wr(68, 16'h20);
        chk("R9 irq high", int'(irq), 1);
        wr(68, 0);
        chk("R9 irq low again", int'(irq), 0);

        // R10 write-one clear
        wr(64, 16'h20);
        rd("R10 cleared", 64, 0);

        // R6 count down to match 0 (mode 1)
        wr(0, 120);
        wr(8, 16'h01);
        cycles(40);
        rd("R6 value at match0", 0, 100);
        rd("R6 halted in mode 1", 8, 16'h11);
        rd("R8 status bit0", 64, 16'h01);

        // R7 forever mode wraps upward, passing match 4
        wr(64, 16'h3F);
        wr(16, 0);
        wr(12, 16'hFFFE);
        wr(20, 16'h0F);
        cycles(4);
        rd("R7 wrapped value", 12, 2);
        wr(20, 16'h10);
        rd("R8 status bit4 on wrap", 64, 16'h10);

        // R4 down count in forever mode
        wr(0, 16'h0103);
        wr(8, 16'h07);
        cycles(3);
        rd("R4 down count", 0, 16'h0100);
        wr(8, 16'h10);

        // R10 clear beats set in the same cycle
        wr(64, 16'h3F);
        wr(0, 98);
        wr(8, 16'h0F);
        cycles(1);
        wr(64, 16'h01);
        rd("R10 clear wins", 64, 0);
        wr(8, 16'h10);

        // R11 value write beats a step
        wr(8, 16'h0F);
        wr(0, 16'h1234);
        rd("R11 write wins", 0, 16'h1234);
        wr(8, 16'h10);
        cycles(2);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule